// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block holds the interrupt state of one core. It takes interrupt requests, each with a vector, a delivery mode and a level/edge flag, and decides whether the core should take an interrupt now. Ordinary requests (the fixed and lowest-priority modes) are kept in three bit arrays, one bit per vector: requested, in service, and level-triggered. Each special mode has a single pending flag and a saved vector.

The core supplies its task-priority value and its interrupt-enable flag. The block raises `intPending` while something may be delivered. When the core raises `ackValid`, the block picks the winner by a fixed ranking and reports its vector and kind with a one-cycle `delValid` pulse. It then updates its state. An end-of-interrupt strobe retires the highest vector in service. A side port reads the trigger-mode bit of any vector.

Top module: `vec_int_arbiter`

## Requirements
- R1: A request with `reqMode` 0 (fixed) or 1 (lowest priority) sets the request bit of `reqVector`. `irrTop` shows the highest vector with its request bit set, or 0 when no request bit is set.
- R2: The trigger-mode bit of a vector (read on `trigSelLevel` for `trigSelect`) takes `reqLevel` only when the request that sets the vector's request bit finds that bit clear. A repeated request leaves the trigger-mode bit unchanged.
- R3: `reqMode` 2 (SMI), 4 (NMI) and 5 (INIT) each latch their own flag and their vector only when that flag is clear. A repeat while the flag is set is dropped. Each counts as unmaskable.
- R4: `reqMode` 7 (external) latches its flag and vector only when that flag is clear. It is not unmaskable.
- R5: `reqMode` 3 and 6 are reserved and change no state.
- R6: `intPending` is 1 when any unmaskable flag is set. Otherwise it is 1 only while `intEnable` is 1 and either the external flag is set, or `irrTop` is above `isrTop` and `irrTop[7:4]` is above `taskPriority[7:4]`.
- R7: An acknowledge taken while `intPending` is 1 delivers one source, in this rank: SMI, NMI, INIT, external, highest fixed vector. `delValid` is 1 for one cycle on the following cycle, together with `delVector` and `delKind`. The kind codes are SMI=1, NMI=2, INIT=3, external=4 and fixed=5. The delivered special flag is cleared.
- R8: Delivering a fixed vector clears its request bit and sets its in-service bit. `isrTop` then equals that vector, and `irrTop` falls to the next-highest request.
- R9: `eoiStrobe` clears the in-service bit of `isrTop`. `isrTop` then shows the next-highest in-service vector, or 0 when none is left.
- R10: After reset all arrays and flags are clear. `intPending`, `delValid`, `delKind`, `irrTop` and `isrTop` are 0.
- R11: An acknowledge while `intPending` is 0 delivers nothing and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqVector | input | 8 | Request vector |
| reqMode | input | 3 | Delivery mode of the request |
| reqLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| intEnable | input | 1 | Core interrupt-enable flag |
| taskPriority | input | 8 | Core task priority; bits [7:4] are compared |
| ackValid | input | 1 | Core acknowledge |
| eoiStrobe | input | 1 | End of interrupt |
| trigSelect | input | 8 | Vector whose trigger-mode bit is read |
| intPending | output | 1 | An interrupt should be taken |
| delValid | output | 1 | One-cycle delivery pulse |
| delVector | output | 8 | Delivered vector |
| delKind | output | 3 | Delivered kind code |
| irrTop | output | 8 | Highest requested vector |
| isrTop | output | 8 | Highest in-service vector |
| trigSelLevel | output | 1 | Trigger-mode bit of `trigSelect` |

## Verification
A request, acknowledge or end-of-interrupt presented on one clock edge changes `intPending`, `irrTop` and `isrTop` after that edge. The delivery pulse appears in the cycle that follows the acknowledge edge. `trigSelLevel` and the priority-gated `intPending` follow `trigSelect`, `taskPriority` and `intEnable` without a clock. The bench drives inputs on the falling edge. It samples registered results at the next falling edge, once exactly one rising edge has passed. It checks the combinational responses a short delay after changing an input, with no edge in between.

// File: rtl/vec_int_pkg.sv
package vec_int_pkg;
  // Delivery mode codes on reqMode
  localparam logic [2:0] MODE_FIXED  = 3'd0;
  localparam logic [2:0] MODE_LOWPRI = 3'd1;
  localparam logic [2:0] MODE_SMI    = 3'd2;
  localparam logic [2:0] MODE_NMI    = 3'd4;
  localparam logic [2:0] MODE_INIT   = 3'd5;
  localparam logic [2:0] MODE_EXT    = 3'd7;

  // Delivered kind codes on delKind
  localparam logic [2:0] KIND_NONE  = 3'd0;
  localparam logic [2:0] KIND_SMI   = 3'd1;
  localparam logic [2:0] KIND_NMI   = 3'd2;
  localparam logic [2:0] KIND_INIT  = 3'd3;
  localparam logic [2:0] KIND_EXT   = 3'd4;
  localparam logic [2:0] KIND_FIXED = 3'd5;

  // Control to datapath strobes
  typedef struct packed {
    logic irrSet;     // latch an ordinary request
    logic fixedAck;   // move irrTop into service
    logic eoiRetire;  // retire isrTop
  } arbStrobes_t;
endpackage

// File: rtl/vec_int_prienc.sv
module vec_int_prienc #(
  parameter  int WIDTH = 256,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [IDX_W-1:0] top
);
  // Highest set index, 0 when the input is all zero
  always_comb begin
    top = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vecIn[i]) top = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vec_int_datapath.sv
module vec_int_datapath
  import vec_int_pkg::*;
#(
  parameter  int VEC_W   = 8,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  arbStrobes_t      st,
  input  logic [VEC_W-1:0] reqVector,
  input  logic             reqLevel,
  input  logic [VEC_W-1:0] trigSelect,
  output logic [VEC_W-1:0] irrTop,
  output logic [VEC_W-1:0] isrTop,
  output logic             trigSelLevel
);
  logic [NUM_VEC-1:0] irrQ, isrQ, tmrQ;
  logic [NUM_VEC-1:0] irrD, isrD, tmrD;
  logic               isrAny;

  vec_int_prienc #(.WIDTH(NUM_VEC)) u_irrEnc (.vecIn(irrQ), .top(irrTop));
  vec_int_prienc #(.WIDTH(NUM_VEC)) u_isrEnc (.vecIn(isrQ), .top(isrTop));

  assign isrAny       = |isrQ;
  assign trigSelLevel = tmrQ[trigSelect];

  always_comb begin
    irrD = irrQ;
    isrD = isrQ;
    tmrD = tmrQ;
    if (st.eoiRetire && isrAny) isrD[isrTop] = 1'b0;
    if (st.fixedAck) begin
      irrD[irrTop] = 1'b0;
      isrD[irrTop] = 1'b1;
    end
    if (st.irrSet) begin
      if (!irrQ[reqVector]) tmrD[reqVector] = reqLevel;
      irrD[reqVector] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrQ <= '0;
      isrQ <= '0;
      tmrQ <= '0;
    end else begin
      irrQ <= irrD;
      isrQ <= isrD;
      tmrQ <= tmrD;
    end
  end
endmodule

// File: rtl/vec_int_control.sv
module vec_int_control
  import vec_int_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic [2:0]       reqMode,
  input  logic             intEnable,
  input  logic [VEC_W-1:0] taskPriority,
  input  logic             ackValid,
  input  logic             eoiStrobe,
  input  logic [VEC_W-1:0] irrTop,
  input  logic [VEC_W-1:0] isrTop,
  output arbStrobes_t      st,
  output logic             intPending,
  output logic             delValid,
  output logic [VEC_W-1:0] delVector,
  output logic [2:0]       delKind
);
  logic             smiP, nmiP, initP, extP, umP;
  logic             smiD, nmiD, initD, extD;
  logic [VEC_W-1:0] smiVec, nmiVec, initVec, extVec;
  logic             fixedReady, ackTake;
  logic [2:0]       pickKind;
  logic [VEC_W-1:0] pickVec;

  assign fixedReady = (irrTop > isrTop) &&
                      (irrTop[VEC_W-1 -: CLASS_W] > taskPriority[VEC_W-1 -: CLASS_W]);
  assign intPending = umP || (intEnable && (extP || fixedReady));
  assign ackTake    = ackValid && intPending;

  always_comb begin
    if (smiP)       begin pickKind = KIND_SMI;   pickVec = smiVec;  end
    else if (nmiP)  begin pickKind = KIND_NMI;   pickVec = nmiVec;  end
    else if (initP) begin pickKind = KIND_INIT;  pickVec = initVec; end
    else if (extP)  begin pickKind = KIND_EXT;   pickVec = extVec;  end
    else            begin pickKind = KIND_FIXED; pickVec = irrTop;  end
  end

  always_comb begin
    smiD  = smiP  && !(ackTake && pickKind == KIND_SMI);
    nmiD  = nmiP  && !(ackTake && pickKind == KIND_NMI);
    initD = initP && !(ackTake && pickKind == KIND_INIT);
    extD  = extP  && !(ackTake && pickKind == KIND_EXT);
    if (reqValid && reqMode == MODE_SMI  && !smiP)  smiD  = 1'b1;
    if (reqValid && reqMode == MODE_NMI  && !nmiP)  nmiD  = 1'b1;
    if (reqValid && reqMode == MODE_INIT && !initP) initD = 1'b1;
    if (reqValid && reqMode == MODE_EXT  && !extP)  extD  = 1'b1;
  end

  always_comb begin
    st.irrSet    = reqValid && (reqMode == MODE_FIXED || reqMode == MODE_LOWPRI);
    st.fixedAck  = ackTake && pickKind == KIND_FIXED;
    st.eoiRetire = eoiStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smiP <= 1'b0; nmiP <= 1'b0; initP <= 1'b0; extP <= 1'b0; umP <= 1'b0;
      smiVec <= '0; nmiVec <= '0; initVec <= '0; extVec <= '0;
      delValid <= 1'b0; delVector <= '0; delKind <= KIND_NONE;
    end else begin
      smiP  <= smiD;
      nmiP  <= nmiD;
      initP <= initD;
      extP  <= extD;
      umP   <= smiD || nmiD || initD;
      if (reqValid && reqMode == MODE_SMI  && !smiP)  smiVec  <= reqVector;
      if (reqValid && reqMode == MODE_NMI  && !nmiP)  nmiVec  <= reqVector;
      if (reqValid && reqMode == MODE_INIT && !initP) initVec <= reqVector;
      if (reqValid && reqMode == MODE_EXT  && !extP)  extVec  <= reqVector;
      delValid <= ackTake;
      if (ackTake) begin
        delVector <= pickVec;
        delKind   <= pickKind;
      end
    end
  end
endmodule

// File: rtl/vec_int_arbiter.sv
module vec_int_arbiter
  import vec_int_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic [2:0]       reqMode,
  input  logic             reqLevel,
  input  logic             intEnable,
  input  logic [VEC_W-1:0] taskPriority,
  input  logic             ackValid,
  input  logic             eoiStrobe,
  input  logic [VEC_W-1:0] trigSelect,
  output logic             intPending,
  output logic             delValid,
  output logic [VEC_W-1:0] delVector,
  output logic [2:0]       delKind,
  output logic [VEC_W-1:0] irrTop,
  output logic [VEC_W-1:0] isrTop,
  output logic             trigSelLevel
);
  arbStrobes_t st;

  vec_int_control #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_ctrl (
    .clk, .rstN, .reqValid, .reqVector, .reqMode, .intEnable, .taskPriority,
    .ackValid, .eoiStrobe, .irrTop, .isrTop, .st, .intPending, .delValid,
    .delVector, .delKind
  );

  vec_int_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk, .rstN, .st, .reqVector, .reqLevel, .trigSelect, .irrTop, .isrTop,
    .trigSelLevel
  );
endmodule

// File: rtl/vec_int_arbiter_chk.sv
module vec_int_arbiter_chk
  import vec_int_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [2:0]       reqMode,
  input logic             intEnable,
  input logic             ackValid,
  input logic             eoiStrobe,
  input logic             intPending,
  input logic             delValid,
  input logic [VEC_W-1:0] delVector,
  input logic [2:0]       delKind,
  input logic [VEC_W-1:0] irrTop,
  input logic [VEC_W-1:0] isrTop
);
  p_del_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    delValid |-> ($past(ackValid) && $past(intPending)));

  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !intPending) |=> !delValid);

  p_masked_kind_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && intPending && !intEnable) |=> (delKind != KIND_EXT && delKind != KIND_FIXED));

  p_fixed_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    (delValid && delKind == KIND_FIXED) |-> (isrTop == delVector));

  p_eoi_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (eoiStrobe && !ackValid && !reqValid && isrTop != '0) |=> (isrTop < $past(isrTop)));

  p_reserved_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqMode == 3'd3 || reqMode == 3'd6) && !ackValid && !eoiStrobe)
      |=> ($stable(irrTop) && $stable(isrTop)));
endmodule

bind vec_int_arbiter vec_int_arbiter_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
  .intEnable(intEnable), .ackValid(ackValid), .eoiStrobe(eoiStrobe),
  .intPending(intPending), .delValid(delValid), .delVector(delVector),
  .delKind(delKind), .irrTop(irrTop), .isrTop(isrTop)
);

// File: tb/vec_int_arbiter_bench.sv
`timescale 1ns/1ps
module vec_int_arbiter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqVector = '0;
  logic [2:0] reqMode = '0;
  logic       reqLevel = 1'b0;
  logic       intEnable = 1'b1;
  logic [7:0] taskPriority = '0;
  logic       ackValid = 1'b0;
  logic       eoiStrobe = 1'b0;
  logic [7:0] trigSelect = '0;
  logic       intPending, delValid, trigSelLevel;
  logic [7:0] delVector, irrTop, isrTop;
  logic [2:0] delKind;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vec_int_arbiter u_vec_int_arbiter (
    .clk, .rstN, .reqValid, .reqVector, .reqMode, .reqLevel, .intEnable,
    .taskPriority, .ackValid, .eoiStrobe, .trigSelect, .intPending, .delValid,
    .delVector, .delKind, .irrTop, .isrTop, .trigSelLevel
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReq(input int vec, input int mode, input bit lvl);
    @(negedge clk);
    reqValid = 1'b1; reqVector = 8'(vec); reqMode = 3'(mode); reqLevel = lvl;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doAck();
    @(negedge clk);
    ackValid = 1'b1;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic doEoi();
    @(negedge clk);
    eoiStrobe = 1'b1;
    @(negedge clk);
    eoiStrobe = 1'b0;
  endtask

  task automatic expDel(input string tag, input int kind, input int vec);
    chk({tag, " delValid"}, int'(delValid), 1);
    chk({tag, " delKind"}, int'(delKind), kind);
    chk({tag, " delVector"}, int'(delVector), vec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 intPending", int'(intPending), 0);
    chk("R10 delValid", int'(delValid), 0);
    chk("R10 delKind", int'(delKind), 0);
    chk("R10 irrTop", int'(irrTop), 0);
    chk("R10 isrTop", int'(isrTop), 0);

    // R11 acknowledge with nothing pending
    doAck();
    chk("R11 idle ack delValid", int'(delValid), 0);
    chk("R11 idle ack isrTop", int'(isrTop), 0);

    // R5 reserved modes change nothing
    doReq(200, 3, 1'b1);
    chk("R5 mode3 irrTop", int'(irrTop), 0);
    chk("R5 mode3 intPending", int'(intPending), 0);
    doReq(200, 6, 1'b1);
    chk("R5 mode6 irrTop", int'(irrTop), 0);
    chk("R5 mode6 intPending", int'(intPending), 0);
    trigSelect = 8'd200; #1;
    chk("R5 trigger untouched", int'(trigSelLevel), 0);

    // R1 ascending sweep of every vector, alternating fixed / lowest priority
    for (int v = 0; v < 256; v++) begin
      doReq(v, (v >> 1) & 1, v[0]);
      chk("R1 irrTop after request", int'(irrTop), v);
    end
    // R2 trigger-mode bits
    for (int v = 0; v < 256; v++) begin
      trigSelect = 8'(v); #1;
      chk("R2 trigger bit", int'(trigSelLevel), v & 1);
    end
    doReq(11, 0, 1'b0);
    trigSelect = 8'd11; #1;
    chk("R2 repeat keeps level", int'(trigSelLevel), 1);
    doReq(12, 1, 1'b1);
    trigSelect = 8'd12; #1;
    chk("R2 repeat keeps edge", int'(trigSelLevel), 0);

    // R6/R7/R8/R9 descending delivery sweep
    for (int v = 255; v >= 16; v--) begin
      for (int tp = 0; tp < 16; tp++) begin
        taskPriority = 8'(tp << 4); #1;
        chk("R6 class vs task priority", int'(intPending), ((v >> 4) > tp) ? 1 : 0);
      end
      taskPriority = 8'h0F; #1;
      chk("R6 low nibble ignored", int'(intPending), 1);
      taskPriority = 8'h00;
      intEnable = 1'b0; #1;
      chk("R6 enable gates fixed", int'(intPending), 0);
      intEnable = 1'b1;
      doAck();
      expDel("R7 fixed", 5, v);
      chk("R8 isrTop", int'(isrTop), v);
      chk("R8 irrTop next", int'(irrTop), v - 1);
      chk("R6 in-service blocks", int'(intPending), 0);
      doEoi();
      chk("R9 isrTop cleared", int'(isrTop), 0);
      chk("R6 after eoi", int'(intPending), (v - 1 >= 16) ? 1 : 0);
    end
    chk("R6 class 0 never pends", int'(intPending), 0);
    chk("R8 remaining irrTop", int'(irrTop), 15);

    // R9 nesting
    doReq(200, 0, 1'b0);
    doAck();
    expDel("R7 nest outer", 5, 200);
    doReq(220, 1, 1'b0);
    chk("R6 higher class preempts", int'(intPending), 1);
    doAck();
    expDel("R7 nest inner", 5, 220);
    chk("R8 nest isrTop", int'(isrTop), 220);
    doEoi();
    chk("R9 nest reveals outer", int'(isrTop), 200);
    doEoi();
    chk("R9 nest empty", int'(isrTop), 0);

    // R3/R4/R6/R7 special modes with interrupts disabled
    doReq(100, 0, 1'b1);
    intEnable = 1'b0; #1;
    chk("R6 disabled no pend", int'(intPending), 0);
    doReq(3, 5, 1'b0);
    chk("R6 INIT unmaskable", int'(intPending), 1);
    doReq(2, 4, 1'b0);
    doReq(1, 2, 1'b0);
    doReq(9, 2, 1'b0);
    doReq(4, 7, 1'b0);
    doReq(7, 7, 1'b0);
    doAck();
    expDel("R3 SMI first", 1, 1);
    doAck();
    expDel("R3 NMI second", 2, 2);
    doAck();
    expDel("R3 INIT third", 3, 3);
    chk("R6 external gated", int'(intPending), 0);
    doAck();
    chk("R11 masked ack delValid", int'(delValid), 0);
    intEnable = 1'b1; #1;
    chk("R4 external pending", int'(intPending), 1);
    doAck();
    expDel("R4 external first vector", 4, 4);
    doAck();
    expDel("R7 fixed last", 5, 100);
    doEoi();
    chk("R9 after special", int'(isrTop), 0);
    doReq(9, 2, 1'b0);
    intEnable = 1'b0; #1;
    chk("R3 SMI relatched", int'(intPending), 1);
    doAck();
    expDel("R3 SMI new vector", 1, 9);
    chk("R3 flags clear", int'(intPending), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule